// File: doc/BRIEF.md
# Block Bit Interleaver with Inverse Mode

This block reorders the coded bits of an OFDM symbol. Bits arrive one per transfer on a valid/ready input and are collected into a block of `SIZE` bits. The whole block then leaves in permuted order on a valid/ready output. The permutation comes from a two-stage index formula. The first stage spreads neighbouring bits across `DEPTH` columns. The second stage rotates bits inside small groups, so that adjacent coded bits land on alternating constellation bit weights. A final offset rotates the whole block for each spatial stream. A mode bit chooses the direction. Gather order interleaves on the transmit side; scatter order applies the exact inverse on the receive side. One hardware instance therefore serves both ends of a link.

Two block buffers alternate between the loading and draining roles. A new block can stream in while the previous one streams out. The input stalls only when both buffers hold complete blocks. Two copies of a counter-based index generator, one per side, produce the permuted addresses. Neither copy divides at run time.

Top module: `ofdm_bit_shuffler`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For position k (0-based), the permuted index is p(k) = (j + SIZE − BPSC·ROT) mod SIZE. Here j = g·floor(i/g) + ((i + SIZE − floor(DEPTH·i/SIZE)) mod g), g = max(BPSC/2, 1) and i = (SIZE/DEPTH)·(k mod DEPTH) + floor(k/DEPTH). With the defaults (SIZE 52, DEPTH 13, BPSC 1, ROT 0), output position 1 carries input bit 4.
- R3: In gather mode (`in_mode` = 0), the k-th bit leaving the block equals input bit p(k) of that block, counting input bits in arrival order from 0.
- R4: In scatter mode (`in_mode` = 1), the output bit at position p(k) equals the k-th input bit of the block.
- R5: `in_mode` is sampled only with the first bit of a block. Its value during the other bits of that block has no effect, and the block drains in the mode it was loaded with.
- R6: While one block waits to drain, a second block is accepted. `in_ready` goes low only when both buffers hold complete blocks, and returns high once the older block has fully drained.
- R7: `out_valid` rises in the cycle after the transfer of the last bit of a block into an empty output side.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_bit` do not change. Input offered while `in_ready` is 0 is not taken.
- R9: A block passed in gather mode and then passed again in scatter mode with the same parameters comes back unchanged.
- R10: The group rotation and the stream offset follow R2 for non-default parameters, for example BPSC 4 and ROT 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Input coded bit |
| in_mode | input | 1 | 0 gather (interleave), 1 scatter (deinterleave); used with a block's first bit |
| in_ready | output | 1 | Block accepts an input bit |
| out_valid | output | 1 | Output bit available |
| out_bit | output | 1 | Output bit |
| out_ready | input | 1 | Consumer takes the output bit |

## Verification
The hardest state to reach is one where both buffers are full, `in_ready` is low, and the two stored blocks were loaded in opposite modes. This state exposes any mix-up between the per-buffer mode flag and the buffer pointers. The bench gets there by holding `out_ready` low while it loads one gather block and then one scatter block back to back. It then pushes ignored input against the stall and checks that the waiting output holds. Finally it drains both blocks and checks each one against its own permutation direction. A second instance with a group size of two and a non-zero stream offset runs in lockstep on the same stimulus, so that the group rotation and the offset are checked on every block.

// File: rtl/ileave_pkg.sv
package ileave_pkg;
    typedef enum logic {
        ORDER_GATHER  = 1'b0,
        ORDER_SCATTER = 1'b1
    } order_e;
endpackage

// File: rtl/perm_index_gen.sv
module perm_index_gen #(
    parameter int SIZE  = 52,
    parameter int DEPTH = 13,
    parameter int BPSC  = 1,
    parameter int ROT   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    output logic [$clog2(SIZE)-1:0] seq_o,
    output logic [$clog2(SIZE)-1:0] perm_o,
    output logic                    last_o
);
    localparam int ROWS  = SIZE / DEPTH;
    localparam int GRP   = (BPSC / 2 > 1) ? BPSC / 2 : 1;
    localparam int SHIFT = (BPSC * ROT) % SIZE;
    localparam int OFF   = (SIZE - SHIFT) % SIZE;
    localparam int KW    = $clog2(SIZE);
    localparam int CW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

    // base holds the first-stage index i; col equals floor(DEPTH*i/SIZE)
    typedef struct packed {
        logic [KW-1:0] k;
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [KW-1:0] base;
    } gen_t;

    gen_t          g_d, g_q;
    logic [KW-1:0] grp_idx;
    logic [KW:0]   rot_sum;

    always_comb begin
        g_d = g_q;
        if (advance) begin
            if (g_q.k == KW'(SIZE - 1)) begin
                g_d = '0;
            end else begin
                g_d.k = g_q.k + KW'(1);
                if (g_q.col == CW'(DEPTH - 1)) begin
                    g_d.col  = '0;
                    g_d.row  = g_q.row + RW'(1);
                    g_d.base = KW'(g_q.row) + KW'(1);
                end else begin
                    g_d.col  = g_q.col + CW'(1);
                    g_d.base = g_q.base + KW'(ROWS);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    generate
        if (GRP == 1) begin : g_no_group
            assign grp_idx = g_q.base;
        end else begin : g_group
            int unsigned iv, cv;
            always_comb begin
                iv      = 32'(g_q.base);
                cv      = 32'(g_q.col);
                grp_idx = KW'((iv / GRP) * GRP + (iv + SIZE - cv) % GRP);
            end
        end
    endgenerate

    always_comb begin
        rot_sum = {1'b0, grp_idx} + (KW+1)'(OFF);
        if (rot_sum >= (KW+1)'(SIZE)) rot_sum = rot_sum - (KW+1)'(SIZE);
    end

    assign perm_o = rot_sum[KW-1:0];
    assign seq_o  = g_q.k;
    assign last_o = (g_q.k == KW'(SIZE - 1));

    assert_perm_in_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        perm_o < KW'(SIZE));
    assert_index_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(perm_o) && $stable(seq_o));
endmodule

// File: rtl/ofdm_bit_shuffler.sv
module ofdm_bit_shuffler
    import ileave_pkg::*;
#(
    parameter int SIZE  = 52,
    parameter int DEPTH = 13,
    parameter int BPSC  = 1,
    parameter int ROT   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    input  logic in_mode,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    input  logic out_ready
);
    localparam int KW  = $clog2(SIZE);
    localparam int NBUF = 2;

    typedef struct packed {
        logic [NBUF-1:0][SIZE-1:0] mem;
        logic [NBUF-1:0]           full;
        logic [NBUF-1:0]           mode;
        logic                      wsel;
        logic                      rsel;
    } core_t;

    core_t                    c_d, c_q;
    logic                     wr_fire, rd_fire;
    logic [NBUF-1:0][KW-1:0]  seq, perm;
    logic [NBUF-1:0]          last;
    order_e                   wmode, rmode;
    logic [KW-1:0]            waddr, raddr;

    // side 0 walks the loading block, side 1 the draining block
    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_side
            perm_index_gen #(
                .SIZE(SIZE), .DEPTH(DEPTH), .BPSC(BPSC), .ROT(ROT)
            ) u_gen (
                .clk    (clk),
                .rst_n  (rst_n),
                .advance((g == 0) ? wr_fire : rd_fire),
                .seq_o  (seq[g]),
                .perm_o (perm[g]),
                .last_o (last[g])
            );
        end
    endgenerate

    always_comb begin
        c_d       = c_q;
        in_ready  = !c_q.full[c_q.wsel];
        wr_fire   = in_valid && in_ready;
        wmode     = (seq[0] == '0) ? order_e'(in_mode) : order_e'(c_q.mode[c_q.wsel]);
        waddr     = (wmode == ORDER_SCATTER) ? perm[0] : seq[0];
        if (wr_fire) begin
            c_d.mem[c_q.wsel][waddr] = in_bit;
            c_d.mode[c_q.wsel]       = wmode;
            if (last[0]) begin
                c_d.full[c_q.wsel] = 1'b1;
                c_d.wsel           = !c_q.wsel;
            end
        end

        out_valid = c_q.full[c_q.rsel];
        rmode     = order_e'(c_q.mode[c_q.rsel]);
        raddr     = (rmode == ORDER_GATHER) ? perm[1] : seq[1];
        out_bit   = c_q.mem[c_q.rsel][raddr];
        rd_fire   = out_valid && out_ready;
        if (rd_fire && last[1]) begin
            c_d.full[c_q.rsel] = 1'b0;
            c_d.rsel           = !c_q.rsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assert_stall_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
    assert_valid_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && last[0]) |=> out_valid);
    assert_output_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_bit));
    assert_mode_kept_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && seq[0] != '0) |=> $stable(c_q.mode));
endmodule

// File: tb/ofdm_bit_shuffler_test.sv
`timescale 1ns/1ps
module ofdm_bit_shuffler_test;
    localparam int N = 52;
    localparam int D = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_mode = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_bit;
    logic in_ready_b, out_valid_b, out_bit_b;

    int checks = 0;
    int fails  = 0;
    logic seen_valid_at_last;

    always #4 clk = ~clk;

    ofdm_bit_shuffler #(.SIZE(N), .DEPTH(D), .BPSC(1), .ROT(0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_mode(in_mode), .in_ready(in_ready), .out_valid(out_valid),
        .out_bit(out_bit), .out_ready(out_ready));

    ofdm_bit_shuffler #(.SIZE(N), .DEPTH(D), .BPSC(4), .ROT(1)) uut_b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_mode(in_mode), .in_ready(in_ready_b), .out_valid(out_valid_b),
        .out_bit(out_bit_b), .out_ready(out_ready));

    // R2 formula, computed with plain division
    function automatic int perm_idx(int k, int bpsc, int rot);
        int i, s, j;
        i = (N / D) * (k % D) + k / D;
        s = (bpsc / 2 > 1) ? bpsc / 2 : 1;
        j = s * (i / s) + ((i + N - (D * i) / N) % s);
        return (j + N - bpsc * rot) % N;
    endfunction

    function automatic logic [N-1:0] permute(logic [N-1:0] d, bit scatter, int bpsc, int rot);
        logic [N-1:0] r = '0;
        for (int k = 0; k < N; k++) begin
            if (!scatter) r[k] = d[perm_idx(k, bpsc, rot)];
            else          r[perm_idx(k, bpsc, rot)] = d[k];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] rand_block();
        return N'({$urandom(), $urandom()});
    endfunction

    task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic send_block(logic [N-1:0] d, bit mode, bit flip);
        int k = 0;
        while (k < N) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = d[k];
            in_mode  = (k == 0) ? mode : (flip ? ~mode : mode);
            if (k == N - 1) seen_valid_at_last = out_valid;
            if (in_ready) k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = 1'b0;
    endtask

    task automatic recv_block(output logic [N-1:0] ga, output logic [N-1:0] gb, input bit stall);
        int j = 0;
        int cyc = 0;
        ga = '0;
        gb = '0;
        while (j < N) begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                ga[j] = out_bit;
                gb[j] = out_bit_b;
                j++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in_ready after reset", N'(in_ready), N'(1));
        chk("R1 out_valid after reset", N'(out_valid), N'(0));
    endtask

    task automatic t_gather();
        logic [N-1:0] d, ga, gb;
        d = 52'hA_5C3F_0912_7E6B;
        fork
            send_block(d, 1'b0, 1'b0);
            recv_block(ga, gb, 1'b0);
        join
        chk("R3 gather block", ga, permute(d, 1'b0, 1, 0));
        chk("R10 gather block bpsc4 rot1", gb, permute(d, 1'b0, 4, 1));
    endtask

    task automatic t_single_bit();
        logic [N-1:0] ga, gb;
        fork
            send_block(N'(1) << 4, 1'b0, 1'b0);
            recv_block(ga, gb, 1'b0);
        join
        chk("R2 input bit 4 lands on output 1", ga, N'(1) << 1);
        chk("R10 single bit bpsc4 rot1", gb, permute(N'(1) << 4, 1'b0, 4, 1));
    endtask

    task automatic t_scatter();
        logic [N-1:0] d, ga, gb;
        d = rand_block();
        fork
            send_block(d, 1'b1, 1'b0);
            recv_block(ga, gb, 1'b1);
        join
        chk("R4 scatter block", ga, permute(d, 1'b1, 1, 0));
        chk("R10 scatter bpsc4 rot1", gb, permute(d, 1'b1, 4, 1));
    endtask

    task automatic t_two_buffers();
        logic [N-1:0] d1, d2, ga, gb;
        logic held;
        d1 = rand_block();
        d2 = rand_block();
        out_ready = 1'b0;
        send_block(d1, 1'b0, 1'b0);
        chk("R7 out_valid low while last bit offered", N'(seen_valid_at_last), N'(0));
        chk("R7 out_valid one cycle after last bit", N'(out_valid), N'(1));
        chk("R6 in_ready with one block waiting", N'(in_ready), N'(1));
        send_block(d2, 1'b1, 1'b0);
        chk("R6 in_ready low with both buffers full", N'(in_ready), N'(0));
        held = out_bit;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = ~in_bit;
            in_mode  = ~in_mode;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = 1'b0;
        chk("R8 out_valid held under stall", N'(out_valid), N'(1));
        chk("R8 out_bit held under stall", N'(out_bit), N'(held));
        recv_block(ga, gb, 1'b0);
        chk("R3 first buffer drains in gather order", ga, permute(d1, 1'b0, 1, 0));
        chk("R10 first buffer bpsc4 rot1", gb, permute(d1, 1'b0, 4, 1));
        chk("R6 in_ready back after drain", N'(in_ready), N'(1));
        recv_block(ga, gb, 1'b1);
        chk("R8 second buffer unchanged by ignored input (scatter)", ga, permute(d2, 1'b1, 1, 0));
        chk("R10 second buffer bpsc4 rot1", gb, permute(d2, 1'b1, 4, 1));
    endtask

    task automatic t_mode_flip();
        logic [N-1:0] d, ga, gb;
        for (int m = 0; m < 2; m++) begin
            d = rand_block();
            fork
                send_block(d, m[0], 1'b1);
                recv_block(ga, gb, 1'b0);
            join
            chk("R5 mode taken from first bit only", ga, permute(d, m[0], 1, 0));
            chk("R5 mode kept bpsc4 rot1", gb, permute(d, m[0], 4, 1));
        end
    endtask

    task automatic t_round_trip();
        logic [N-1:0] d, x, y, xb, yb;
        for (int it = 0; it < 3; it++) begin
            d = rand_block();
            fork
                send_block(d, 1'b0, 1'b0);
                recv_block(x, xb, 1'b1);
            join
            fork
                send_block(x, 1'b1, 1'b0);
                recv_block(y, yb, 1'b0);
            join
            chk("R9 gather then scatter restores block", y, d);
            chk("R10 scatter of foreign block bpsc4 rot1", yb, permute(x, 1'b1, 4, 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gather();
        t_single_bit();
        t_scatter();
        t_two_buffers();
        t_mode_flip();
        t_round_trip();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule